// File: doc/BRIEF.md
# Timer Channel Clock-Enable Generator

This block produces the count enables for a bank of timer channels, and the chip's system clock drives all of its logic. It has ten channels: eight general timers, one operating-system timer and one watchdog timer. Each channel has a 16-bit control word with two fields. The first field picks one of three source ticks: the peripheral tick, the RTC tick or the external tick. The second field picks a power-of-four divide ratio, from /1 up to /1024. The channel counts the edges of its chosen source and raises its enable output for one system-clock cycle each time the count wraps. The timer counter downstream advances on that enable.

All ten channels have their gate bits in one shared stop register. Software reads the stop register at its own address. It changes the register through two write-only aliases: one sets bits and the other clears them. A stopped channel stays silent and its divider is held at zero. Its control word is also locked: writes to it are dropped and reads of it return zero. Software therefore has to clear a channel's stop bit before it can program the channel. The three source ticks arrive already synchronised to the system clock, one cycle wide each.

Top module: `tmrclk_unit`

## Requirements
- R1: After reset, every implemented stop bit reads 1, every control word is zero, and no enable output pulses. With the default of eight timers the stop register reads 0x0001_80FF.
- R2: The stop register reads at address 0x00. General timer n owns stop bit n, the operating-system timer owns bit 15 and the watchdog owns bit 16. Every other bit reads 0. A bit value of 1 means the channel is gated off. Without a write to an alias, the register does not change.
- R3: A write to address 0x04 sets each stop bit whose data bit is 1 and leaves the other stop bits as they were. This alias reads as 0.
- R4: A write to address 0x08 clears each stop bit whose data bit is 1 and leaves the other stop bits as they were. This alias reads as 0.
- R5: The control word of general timer n is at 0x10 + 4n, the operating-system timer's at 0x3C and the watchdog's at 0x40. While a channel runs, a write stores data bits [15:0] and a read returns them. Any other address reads 0.
- R6: While a channel's stop bit is 1, writes to its control word are dropped and reads of it return 0.
- R7: Control bits [2:0] select the source: bit 0 is the peripheral tick, bit 1 the RTC tick and bit 2 the external tick. When more than one bit is set, the lowest set bit decides. When none is set, the channel gives no enables.
- R8: Control bits [5:3] hold the prescale value p. The channel raises its enable once for every 4^p selected source ticks. Values 6 and 7 act as 5, which is /1024. The enable is high in the cycle after the source tick that completes the count.
- R9: The divider restarts from zero when an accepted write changes bits [5:0], and when the channel is stopped. After a restart, the first enable follows exactly 4^p source ticks.
- R10: A stopped channel raises no enable, whatever its source ticks do.
- R11: Channels run independently. Ticks and settings on one channel do not change the enables of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pclk_tk | input | 1 | Peripheral source tick |
| rtc_tk | input | 1 | RTC source tick |
| ext_tk | input | 1 | External source tick |
| tick_o | output | 10 | Enables: bits 7..0 general timers, bit 8 operating-system timer, bit 9 watchdog |

## Verification
A wrong stop bit shows at once on a read of address 0x00. On the next cycle it also shows at the ports as an enable that should not be there, or as a control read that returns a value where zero was expected. A divider left holding an old count, or one that fails to restart when its fields change or its channel stops, does not show until the next wrap. The enable then lands fewer than 4^p source ticks after the restart, so the bench counts enables over exact tick runs just below and just at each ratio. A fault in source selection shows within a single source tick, as an enable on the wrong source or as a missing one.

// File: rtl/tmrclk_pkg.sv
package tmrclk_pkg;

    localparam int HALT_W      = 17;
    localparam int OS_HALT_BIT = 15;
    localparam int WD_HALT_BIT = 16;
    localparam int PSC_MAX     = 5;
    localparam int DIV_W       = 2 * PSC_MAX;

    localparam int A_HALT     = 'h00;
    localparam int A_SET      = 'h04;
    localparam int A_CLR      = 'h08;
    localparam int A_TMR_BASE = 'h10;
    localparam int A_OS       = 'h3C;
    localparam int A_WD       = 'h40;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PCLK,
        SRC_RTC,
        SRC_EXT
    } src_e;

    // Low six bits of a control word: prescale above, one-hot select below.
    typedef struct packed {
        logic [2:0] psc;
        logic [2:0] sel;
    } ctl_fld_t;

    localparam int FLD_W = $bits(ctl_fld_t);

    // The lowest set select bit decides.
    function automatic src_e pick_src(input logic [2:0] sel);
        if (sel[0])      return SRC_PCLK;
        else if (sel[1]) return SRC_RTC;
        else if (sel[2]) return SRC_EXT;
        else             return SRC_NONE;
    endfunction

    function automatic logic [2:0] clamp_psc(input logic [2:0] p);
        return (p > 3'(PSC_MAX)) ? 3'(PSC_MAX) : p;
    endfunction

    // Terminal count of the divider: 4^p - 1.
    function automatic logic [DIV_W-1:0] wrap_val(input logic [2:0] p);
        logic [DIV_W:0] full;
        full = ({{DIV_W{1'b0}}, 1'b1} << (2 * clamp_psc(p))) - 1'b1;
        return full[DIV_W-1:0];
    endfunction

    function automatic int halt_bit(input int ch, input int ntmr);
        if (ch < ntmr)       return ch;
        else if (ch == ntmr) return OS_HALT_BIT;
        else                 return WD_HALT_BIT;
    endfunction

    function automatic int ctl_addr(input int ch, input int ntmr);
        if (ch < ntmr)       return A_TMR_BASE + 4 * ch;
        else if (ch == ntmr) return A_OS;
        else                 return A_WD;
    endfunction

    function automatic logic [HALT_W-1:0] halt_mask(input int ntmr);
        logic [HALT_W-1:0] m;
        m = '0;
        for (int i = 0; i < ntmr; i++) m[i] = 1'b1;
        m[OS_HALT_BIT] = 1'b1;
        m[WD_HALT_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tmrclk_halt.sv
module tmrclk_halt
    import tmrclk_pkg::*;
#(
    parameter int                W    = HALT_W,
    parameter logic [HALT_W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] halt_o
);

    localparam logic [W-1:0] M = W'(MASK);

    logic [W-1:0] halt_q;
    logic [W-1:0] hit;

    assign hit    = wdata & M;
    assign halt_o = halt_q;

    always_ff @(posedge clk) begin
        if (rst)         halt_q <= M;
        else if (set_we) halt_q <= halt_q | hit;
        else if (clr_we) halt_q <= halt_q & ~hit;
    end

    AST_SET_APPLIED: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((halt_q & $past(hit)) == $past(hit))); // R3
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((halt_q & ~$past(wdata)) == ($past(halt_q) & ~$past(wdata)))); // R3
    AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((halt_q & $past(hit)) == '0)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(halt_q)); // R2

endmodule

// File: rtl/tmrclk_chan.sv
module tmrclk_chan
    import tmrclk_pkg::*;
#(
    parameter int CTL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_i,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic [2:0]       src_tk_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             tick_o
);

    logic [CTL_W-1:0] ctl_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    ctl_fld_t         fld_q;
    ctl_fld_t         fld_new;
    logic             accept;
    logic             fld_chg;
    logic             src_tk;
    logic             at_wrap;

    assign fld_q   = ctl_fld_t'(ctl_q[FLD_W-1:0]);
    assign fld_new = ctl_fld_t'(wdata_i[FLD_W-1:0]);
    assign accept  = wr_i && !halt_i;
    assign fld_chg = accept && (fld_new != fld_q);
    assign at_wrap = (cnt_q == wrap_val(fld_q.psc));

    always_comb begin
        case (pick_src(fld_q.sel))
            SRC_PCLK: src_tk = src_tk_i[0];
            SRC_RTC:  src_tk = src_tk_i[1];
            SRC_EXT:  src_tk = src_tk_i[2];
            default:  src_tk = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            if (accept) ctl_q <= wdata_i;
            tick_q <= 1'b0;
            if (halt_i || fld_chg) begin
                cnt_q <= '0;
            end else if (src_tk) begin
                if (at_wrap) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ctl_o  = halt_i ? '0 : ctl_q;
    assign tick_o = tick_q;

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> !tick_o); // R10
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_i && halt_i) |=> $stable(ctl_q)); // R6
    AST_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (fld_q.sel == 3'b000) |=> !tick_o); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= wrap_val(fld_q.psc)); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (halt_i || fld_chg) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/tmrclk_unit.sv
module tmrclk_unit
    import tmrclk_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CTL_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_we,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 pclk_tk,
    input  logic                 rtc_tk,
    input  logic                 ext_tk,
    output logic [NUM_TMR+1:0]   tick_o
);

    localparam int                NUM_CH = NUM_TMR + 2;
    localparam logic [HALT_W-1:0] HMASK  = halt_mask(NUM_TMR);

    logic [HALT_W-1:0] halt_q;
    logic [CTL_W-1:0]  ctl_rd [NUM_CH];
    logic [2:0]        src_vec;
    logic              set_we;
    logic              clr_we;
    logic              unused_wdata;

    assign src_vec      = {ext_tk, rtc_tk, pclk_tk};
    assign set_we       = bus_we && (bus_addr == ADDR_W'(A_SET));
    assign clr_we       = bus_we && (bus_addr == ADDR_W'(A_CLR));
    assign unused_wdata = ^bus_wdata[DATA_W-1:HALT_W];

    tmrclk_halt #(
        .W    (HALT_W),
        .MASK (HMASK)
    ) u_halt (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we),
        .clr_we (clr_we),
        .wdata  (bus_wdata[HALT_W-1:0]),
        .halt_o (halt_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int HB = halt_bit(c, NUM_TMR);
        localparam int CA = ctl_addr(c, NUM_TMR);
        logic wr_sel;
        assign wr_sel = bus_we && (bus_addr == ADDR_W'(CA));

        tmrclk_chan #(
            .CTL_W (CTL_W)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .halt_i   (halt_q[HB]),
            .wr_i     (wr_sel),
            .wdata_i  (bus_wdata[CTL_W-1:0]),
            .src_tk_i (src_vec),
            .ctl_o    (ctl_rd[c]),
            .tick_o   (tick_o[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_HALT)) bus_rdata = DATA_W'(halt_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(ctl_addr(c, NUM_TMR))) bus_rdata = DATA_W'(ctl_rd[c]);
        end
    end

    AST_RESET_ALL_STOPPED: assert property (@(posedge clk)
        rst |=> (halt_q == HMASK)); // R1
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (halt_q[WD_HALT_BIT] && !clr_we) |=> !tick_o[NUM_CH-1]); // R10

endmodule

// File: tb/tmrclk_unit_bench.sv
`timescale 1ns/1ps
module tmrclk_unit_bench;

    localparam int NCH = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [2:0]  src = '0;
    logic [NCH-1:0] tick_o;

    int checks = 0;
    int fails  = 0;
    int cnt [NCH];

    always #4 clk = ~clk;

    tmrclk_unit u_tmrclk_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pclk_tk   (src[0]),
        .rtc_tk    (src[1]),
        .ext_tk    (src[2]),
        .tick_o    (tick_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  req;
    } op_t;

    localparam int NOPS = 21;
    localparam op_t OPS [NOPS] = '{
        '{1'b0, 8'h00, 32'h0001_80FF, 4'd1},  // R1 R2 reset status
        '{1'b0, 8'h10, 32'h0000_0000, 4'd1},  // R1
        '{1'b1, 8'h10, 32'h0000_0009, 4'd6},  // locked write
        '{1'b1, 8'h08, 32'h0000_0001, 4'd4},
        '{1'b0, 8'h00, 32'h0001_80FE, 4'd4},  // R4
        '{1'b0, 8'h10, 32'h0000_0000, 4'd6},  // R6 write dropped
        '{1'b1, 8'h10, 32'h1234_ABCD, 4'd5},
        '{1'b0, 8'h10, 32'h0000_ABCD, 4'd5},  // R5
        '{1'b1, 8'h08, 32'h0001_8002, 4'd4},
        '{1'b0, 8'h00, 32'h0000_00FC, 4'd4},  // R4
        '{1'b1, 8'h04, 32'h0000_0002, 4'd3},
        '{1'b0, 8'h00, 32'h0000_00FE, 4'd3},  // R3
        '{1'b1, 8'h3C, 32'h0000_0007, 4'd5},
        '{1'b0, 8'h3C, 32'h0000_0007, 4'd5},  // R5
        '{1'b1, 8'h40, 32'h0000_0022, 4'd5},
        '{1'b0, 8'h40, 32'h0000_0022, 4'd5},  // R5
        '{1'b0, 8'h14, 32'h0000_0000, 4'd6},  // R6
        '{1'b0, 8'h04, 32'h0000_0000, 4'd3},  // R3 alias reads 0
        '{1'b1, 8'h04, 32'h0001_FFFF, 4'd3},
        '{1'b0, 8'h00, 32'h0001_80FF, 4'd3},  // R3 unused bits stay 0
        '{1'b0, 8'h3C, 32'h0000_0000, 4'd6}   // R6
    };

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, $sformatf("read 0x%02h", a), bus_rdata, exp);
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        for (int i = 0; i < n; i++) begin
            src = m;
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (tick_o[c]) cnt[c]++;
        end
        src = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(1, "ticks after reset", 32'(tick_o), 32'h0);

        for (int i = 0; i < NOPS; i++) begin
            if (OPS[i].wr) wr_reg(OPS[i].a, OPS[i].d);
            else           rd_chk(int'(OPS[i].req), OPS[i].a, OPS[i].d);
        end

        // R8: channel 2, peripheral source, /4
        wr_reg(8'h08, 32'h4);
        wr_reg(8'h18, 32'h09);
        pulse(3'b001, 3);
        chk(8, "/4 after 3 ticks", cnt[2], 0);
        pulse(3'b001, 1);
        chk(8, "/4 on 4th tick", cnt[2], 1);
        pulse(3'b001, 4);
        chk(10, "stopped ch0 silent", cnt[0], 0);
        chk(10, "stopped os silent", cnt[8], 0);

        // R7: lowest select bit wins, empty select is silent
        wr_reg(8'h18, 32'h06);
        pulse(3'b100, 5);
        chk(7, "rtc|ext ignores ext", cnt[2], 0);
        pulse(3'b010, 5);
        chk(7, "rtc|ext uses rtc", cnt[2], 5);
        wr_reg(8'h18, 32'h07);
        pulse(3'b010, 3);
        chk(7, "all sel ignores rtc", cnt[2], 0);
        pulse(3'b001, 3);
        chk(7, "all sel uses pclk", cnt[2], 3);
        wr_reg(8'h18, 32'h08);
        pulse(3'b111, 8);
        chk(7, "no select", cnt[2], 0);

        // R8: prescale 6 clamps to /1024, then 5 directly
        wr_reg(8'h18, 32'h31);
        pulse(3'b001, 1023);
        chk(8, "p=6 before 1024", cnt[2], 0);
        pulse(3'b001, 1);
        chk(8, "p=6 at 1024", cnt[2], 1);
        wr_reg(8'h18, 32'h29);
        pulse(3'b001, 1023);
        chk(8, "p=5 before 1024", cnt[2], 0);
        pulse(3'b001, 1);
        chk(8, "p=5 at 1024", cnt[2], 1);

        // R9: field change restarts divider
        wr_reg(8'h18, 32'h09);
        pulse(3'b001, 3);
        chk(9, "partial count", cnt[2], 0);
        wr_reg(8'h18, 32'h11);
        pulse(3'b001, 15);
        chk(9, "after change before 16", cnt[2], 0);
        pulse(3'b001, 1);
        chk(9, "after change at 16", cnt[2], 1);

        // R9 / R10: stopping restarts and silences
        wr_reg(8'h18, 32'h09);
        pulse(3'b001, 3);
        wr_reg(8'h04, 32'h4);
        pulse(3'b001, 8);
        chk(10, "stopped ch2 silent", cnt[2], 0);
        rd_chk(6, 8'h18, 32'h0);
        wr_reg(8'h08, 32'h4);
        rd_chk(5, 8'h18, 32'h09);
        pulse(3'b001, 3);
        chk(9, "after stop before 4", cnt[2], 0);
        pulse(3'b001, 1);
        chk(9, "after stop at 4", cnt[2], 1);

        // R11: channels independent
        wr_reg(8'h08, 32'h8000);
        pulse(3'b001, 8);
        chk(11, "ch2 /4", cnt[2], 2);
        chk(11, "os /1", cnt[8], 8);
        chk(11, "ch0 stopped", cnt[0], 0);
        chk(11, "wd stopped", cnt[9], 0);

        // R1: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_chk(1, 8'h00, 32'h0001_80FF);
        wr_reg(8'h08, 32'h4);
        rd_chk(1, 8'h18, 32'h0);
        pulse(3'b001, 4);
        chk(1, "no ticks after reset", cnt[2], 0);
        rd_chk(5, 8'h44, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule